// File: doc/BRIEF.md
# Memory-Mapped Byte Network Port

This block is a small network-card style peripheral on a byte-wide load/store bus. Software reaches three registers: a status and control register, a transmit data register and a receive data register. On the line side, outgoing bytes leave over a valid/ready handshake toward a serializer. Incoming bytes arrive over a valid/ready handshake from a deserializer that the port always accepts.

The two status flags have split ownership. Software raises the transmit-busy flag after loading a byte, and the port drops it once the line side has taken the byte. The port raises the receive-full flag when a byte lands, and software drops it after reading. A level interrupt tells software that the transmitter is idle or that a byte is waiting, gated by two enable bits in the same register.

Top module: `bmp_port`

## Requirements
- R1: Once reset is released, the status register reads 0x00, `irq` and `tx_valid` are low, and `rx_ready` is high one clock after reset is released.
- R2: The status register is decoded at address 97, the transmit register at address 98 and the receive register at address 99. A read at any other address returns zero. Status bit layout: bit 0 is transmit busy, bit 1 is receive full, bit 2 is overrun, bit 4 enables the transmit-idle interrupt and bit 5 enables the receive interrupt. All other bits read zero.
- R3: A status write with bit 0 set while the transmitter is idle sets bit 0 and presents the transmit register on `tx_data` with `tx_valid` high. The clock edge that sees `tx_valid` and `tx_ready` both high ends the transfer, and bit 0 reads zero afterwards.
- R4: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged.
- R5: A byte accepted on the receive handshake is stored, status bit 1 is set, and a read of address 99 returns the last byte received, also after bit 1 has been cleared.
- R6: A status write with bit 1 equal to 0 clears bit 1 and bit 2. A status write with bit 1 equal to 1 leaves both unchanged.
- R7: A byte that arrives while bit 1 is set replaces the stored byte and sets bit 2. Bit 2 then stays set until software clears it as described in R6.
- R8: While bit 0 is set, writes to address 98 have no effect, a status write with bit 0 set does not start a second transfer, and a status write with bit 0 equal to 0 does not clear bit 0.
- R9: `irq` is high exactly when (bit 4 is set and bit 0 is clear) or (bit 5 is set and bit 1 is set).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the addressed register |
| tx_valid | output | 1 | Outgoing byte is valid |
| tx_ready | input | 1 | Line side takes the outgoing byte |
| tx_data | output | DATA_W | Outgoing byte |
| rx_valid | input | 1 | Incoming byte is valid |
| rx_ready | output | 1 | Port accepts incoming bytes |
| rx_data | input | DATA_W | Incoming byte |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that every wire-side input has a known value after reset and that `tx_ready` is the only thing that can end a transfer. They also assume software never clears the receive flag in the same cycle that a byte arrives, because the port resolves that collision in favour of the arrival. The stimulus drives all inputs on the falling edge. It pulses `rx_valid` for exactly one cycle at a time and always reads status between an arrival and a clear. It holds `tx_ready` low for several cycles before granting it, so that the hold and ignore rules are exercised against a stalled line.

// File: rtl/bmp_pkg.sv
package bmp_pkg;
   localparam int ST_BUSY = 0;
   localparam int ST_FULL = 1;
   localparam int ST_OVR  = 2;
   localparam int ST_TXIE = 4;
   localparam int ST_RXIE = 5;
   localparam int ST_MSB  = 5;

   typedef enum logic [1:0] {
      REG_NONE = 2'd0,
      REG_STAT = 2'd1,
      REG_TX   = 2'd2,
      REG_RX   = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/bmp_decode.sv
module bmp_decode
   import bmp_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int STAT_ADDR = 97,
   parameter int TX_ADDR   = 98,
   parameter int RX_ADDR   = 99
) (
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   output reg_sel_e          region,
   output logic              wr_stat,
   output logic              wr_tx
);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
   localparam logic [ADDR_W-1:0] A_TX   = ADDR_W'(TX_ADDR);
   localparam logic [ADDR_W-1:0] A_RX   = ADDR_W'(RX_ADDR);

   always_comb begin
      region = REG_NONE;
      if (bus_addr == A_STAT)    region = REG_STAT;
      else if (bus_addr == A_TX) region = REG_TX;
      else if (bus_addr == A_RX) region = REG_RX;
   end

   assign wr_stat = bus_sel && bus_we && (region == REG_STAT);
   assign wr_tx   = bus_sel && bus_we && (region == REG_TX);
endmodule

// File: rtl/bmp_tx_chan.sv
module bmp_tx_chan
   import bmp_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_tx,
   input  logic              wr_stat,
   input  logic [DATA_W-1:0] wdata,
   input  logic              tx_ready,
   output logic              busy,
   output logic [DATA_W-1:0] tx_q
);
   logic start;
   assign start = wr_stat && wdata[ST_BUSY] && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         tx_q <= '0;
      end else begin
         if (wr_tx && !busy) tx_q <= wdata;
         if (busy && tx_ready) busy <= 1'b0;
         else if (start)       busy <= 1'b1;
      end
   end
endmodule

// File: rtl/bmp_rx_chan.sv
module bmp_rx_chan
   import bmp_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stat,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              full,
   output logic              ovr,
   output logic [DATA_W-1:0] rx_q
);
   logic clr, take;
   assign clr  = wr_stat && !wdata[ST_FULL];
   assign take = rx_valid && rx_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_ready <= 1'b0;
         full     <= 1'b0;
         ovr      <= 1'b0;
         rx_q     <= '0;
      end else begin
         rx_ready <= 1'b1;
         if (take) begin
            rx_q <= rx_data;
            full <= 1'b1;
            if (full && !clr) ovr <= 1'b1;
         end else if (clr) begin
            full <= 1'b0;
            ovr  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/bmp_irq.sv
module bmp_irq
   import bmp_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stat,
   input  logic [DATA_W-1:0] wdata,
   input  logic              busy,
   input  logic              full,
   output logic              tx_ie,
   output logic              rx_ie,
   output logic              irq
);
   logic level;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_ie <= 1'b0;
         rx_ie <= 1'b0;
      end else if (wr_stat) begin
         tx_ie <= wdata[ST_TXIE];
         rx_ie <= wdata[ST_RXIE];
      end
   end

   assign level = (tx_ie && !busy) || (rx_ie && full);

   generate
      if (IRQ_REG) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= level;
         end
         assign irq = irq_q;
      end else begin : g_comb
         assign irq = level;
      end
   endgenerate
endmodule

// File: rtl/bmp_port.sv
module bmp_port
   import bmp_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   parameter int STAT_ADDR = 97,
   parameter int TX_ADDR   = 98,
   parameter int RX_ADDR   = 99,
   parameter bit IRQ_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [DATA_W-1:0] tx_data,
   input  logic              rx_valid,
   output logic              rx_ready,
   input  logic [DATA_W-1:0] rx_data,
   output logic              irq
);
   localparam int ADDR_SPAN = 1 << ADDR_W;

   generate
      if (DATA_W <= ST_MSB)
         $error("DATA_W too narrow for the status layout");
      if (STAT_ADDR >= ADDR_SPAN || TX_ADDR >= ADDR_SPAN || RX_ADDR >= ADDR_SPAN)
         $error("register address outside ADDR_W");
      if (STAT_ADDR == TX_ADDR || STAT_ADDR == RX_ADDR || TX_ADDR == RX_ADDR)
         $error("register addresses must differ");
   endgenerate

   reg_sel_e          region;
   logic              wr_stat, wr_tx;
   logic              busy, rx_full, rx_ovr, tx_ie, rx_ie;
   logic [DATA_W-1:0] tx_q, rx_q, stat_v;

   bmp_decode #(
      .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .TX_ADDR(TX_ADDR), .RX_ADDR(RX_ADDR)
   ) u_dec (
      .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .region(region), .wr_stat(wr_stat), .wr_tx(wr_tx)
   );

   bmp_tx_chan #(.DATA_W(DATA_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .wr_tx(wr_tx), .wr_stat(wr_stat),
      .wdata(bus_wdata), .tx_ready(tx_ready), .busy(busy), .tx_q(tx_q)
   );

   bmp_rx_chan #(.DATA_W(DATA_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .wr_stat(wr_stat), .wdata(bus_wdata),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
      .full(rx_full), .ovr(rx_ovr), .rx_q(rx_q)
   );

   bmp_irq #(.DATA_W(DATA_W), .IRQ_REG(IRQ_REG)) u_irq (
      .clk(clk), .rst_n(rst_n), .wr_stat(wr_stat), .wdata(bus_wdata),
      .busy(busy), .full(rx_full), .tx_ie(tx_ie), .rx_ie(rx_ie), .irq(irq)
   );

   always_comb begin
      stat_v          = '0;
      stat_v[ST_BUSY] = busy;
      stat_v[ST_FULL] = rx_full;
      stat_v[ST_OVR]  = rx_ovr;
      stat_v[ST_TXIE] = tx_ie;
      stat_v[ST_RXIE] = rx_ie;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel) begin
         unique case (region)
            REG_STAT: bus_rdata = stat_v;
            REG_TX:   bus_rdata = tx_q;
            REG_RX:   bus_rdata = rx_q;
            default:  bus_rdata = '0;
         endcase
      end
   end

   assign tx_valid = busy;
   assign tx_data  = tx_q;
endmodule

// File: rtl/bmp_port_chk.sv
module bmp_port_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_valid,
   input logic              tx_ready,
   input logic [DATA_W-1:0] tx_data,
   input logic              rx_valid,
   input logic              rx_ready,
   input logic              full,
   input logic              ovr
);
   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R4
   AST_TX_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && tx_ready |=> !tx_valid); // R3
   AST_TX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |=> !tx_valid || $stable(tx_data)); // R8
   AST_RX_SET: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && rx_ready |=> full); // R5
   AST_RX_OVR: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && rx_ready && full |=> ovr); // R7
   AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      ovr |-> full); // R6
endmodule

bind bmp_port bmp_port_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
   .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
   .full(rx_full), .ovr(rx_ovr)
);

// File: tb/tb_bmp_port.sv
module tb_bmp_port;
   localparam int CLK_P  = 10;
   localparam int ADDR_W = 8;
   localparam int DATA_W = 8;
   localparam logic [7:0] A_ST = 8'd97, A_TX = 8'd98, A_RX = 8'd99;

   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_sel = 0, bus_we = 0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [DATA_W-1:0] bus_wdata = '0, bus_rdata;
   logic tx_valid, tx_ready = 0, rx_valid = 0, rx_ready, irq;
   logic [DATA_W-1:0] tx_data, rx_data = '0;
   int checks = 0, errors = 0;

   always #(CLK_P/2) clk = ~clk;

   bmp_port dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
      .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .irq(irq)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_we = 0;
   endtask

   task automatic rd(logic [7:0] a, output logic [7:0] d);
      bus_sel = 1; bus_we = 0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 0;
   endtask

   task automatic rx_byte(logic [7:0] d);
      @(negedge clk);
      rx_valid = 1; rx_data = d;
      @(negedge clk);
      rx_valid = 0;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      @(negedge clk);
      rd(A_ST, v);   check("R1 status", v, 8'h00);
      check("R1 irq", irq, 0);
      check("R1 tx_valid", tx_valid, 0);
      check("R1 rx_ready", rx_ready, 1);
      rd(8'd50, v);  check("R2 unmapped", v, 8'h00);
   endtask

   task automatic t_tx();
      logic [7:0] v;
      wr(A_TX, 8'h5A);
      check("R3 no start", tx_valid, 0);
      rd(A_TX, v);   check("R2 tx read", v, 8'h5A);
      wr(A_ST, 8'h01);
      rd(A_ST, v);   check("R3 busy", v, 8'h01);
      check("R3 tx_valid", tx_valid, 1);
      check("R3 tx_data", tx_data, 8'h5A);
      repeat (3) @(negedge clk);
      check("R4 hold valid", tx_valid, 1);
      check("R4 hold data", tx_data, 8'h5A);
      wr(A_TX, 8'hFF);
      check("R8 tx ignored", tx_data, 8'h5A);
      rd(A_TX, v);   check("R8 tx reg", v, 8'h5A);
      wr(A_ST, 8'h00);
      rd(A_ST, v);   check("R8 no sw clear", v, 8'h01);
      wr(A_ST, 8'h01);
      @(negedge clk); tx_ready = 1;
      @(negedge clk);
      check("R3 done", tx_valid, 0);
      @(negedge clk); tx_ready = 0;
      check("R8 no second send", tx_valid, 0);
      rd(A_ST, v);   check("R3 status idle", v, 8'h00);
   endtask

   task automatic t_rx();
      logic [7:0] v;
      rx_byte(8'h3C);
      rd(A_ST, v);   check("R5 full", v, 8'h02);
      rd(A_RX, v);   check("R5 data", v, 8'h3C);
      wr(A_ST, 8'h02);
      rd(A_ST, v);   check("R6 keep", v, 8'h02);
      wr(A_ST, 8'h00);
      rd(A_ST, v);   check("R6 clear", v, 8'h00);
      rd(A_RX, v);   check("R5 last byte", v, 8'h3C);
   endtask

   task automatic t_ovr();
      logic [7:0] v;
      rx_byte(8'h11);
      rx_byte(8'h22);
      rd(A_ST, v);   check("R7 overrun", v, 8'h06);
      rd(A_RX, v);   check("R7 overwrite", v, 8'h22);
      repeat (2) @(negedge clk);
      rd(A_ST, v);   check("R7 sticky", v, 8'h06);
      wr(A_ST, 8'h00);
      rd(A_ST, v);   check("R6 clear ovr", v, 8'h00);
   endtask

   task automatic t_irq();
      logic [7:0] v;
      wr(A_ST, 8'h10);
      check("R9 tx idle irq", irq, 1);
      rd(A_ST, v);   check("R2 enables", v, 8'h10);
      wr(A_ST, 8'h11);
      check("R9 busy no irq", irq, 0);
      @(negedge clk); tx_ready = 1;
      @(negedge clk); tx_ready = 0;
      check("R9 idle again", irq, 1);
      wr(A_ST, 8'h20);
      check("R9 rx empty", irq, 0);
      rx_byte(8'h77);
      check("R9 rx irq", irq, 1);
      wr(A_ST, 8'h20);
      check("R9 rx cleared", irq, 0);
   endtask

   initial begin
      #(CLK_P * 20000);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_tx();
      t_rx();
      t_ovr();
      t_irq();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule